// File: doc/BRIEF.md
# SATD Intra Mode Decision Engine

This block picks the intra prediction modes for one macroblock by comparing candidate predictions through their SATD cost. A neighbouring prediction unit hands over one 4x4 block pair at a time: the current pixels and a candidate prediction of them. A two-stage Hadamard unit turns each pair into a cost. Three running-minimum trackers keep the cheapest mode for each of the sixteen 4x4 luma blocks, for the 16x16 luma prediction and for the chroma prediction.

When the last chroma candidate has been costed, a five-step sequencer with one shared adder builds a mode-signalling penalty of 24 times lambda. It adds this penalty to the summed 4x4 luma cost and tests the sign of the 16x16 cost minus that sum. A one-cycle `done_o` pulse then presents the chosen modes, the decision and the winning costs to the coder. The outputs hold these values until the next macroblock finishes.

Top module: `intra_mode_decide`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` and `blk_ready_o` are 0 and all result outputs are 0 until the first macroblock completes.
- R2: `start_i` is taken only while no macroblock is in progress. After that, exactly 240 block pairs are accepted, one at a time. `blk_ready_o` is 0 from the cycle after an accepted pair until its cost is known, and it stays 0 after the last pair. A `start_i` pulse during a run has no effect on the accepted count or the results.
- R3: The cost of a pair is half the sum of the absolute values of the 2-D 4x4 Hadamard transform of (current minus prediction). Pixel i = 4*row+col sits at bits [8i+7:8i] of `cur_blk_i` and `pred_blk_i`.
- R4: The first 144 pairs are 4x4 luma: block 0..15 in the outer loop, mode 0..8 in the inner loop. Field [4b+3:4b] of `l4_modes_o` gives the lowest-cost mode of block b. On equal cost the lower mode number is kept.
- R5: `cost4_o` is the sum of the sixteen per-block minimum 4x4 costs.
- R6: The next 64 pairs are 16x16 luma: mode 0..3 in the outer loop, block 0..15 in the inner loop. Each mode's cost is its 16-block sum. `l16_mode_o` is the cheapest mode, with the lower number kept on ties, and `cost16_o` is its cost.
- R7: The last 32 pairs are chroma: mode 0..3 in the outer loop, block 0..7 in the inner loop. Summation, tie rule and outputs (`ch_mode_o`, `cost_ch_o`) follow R6.
- R8: `use16_o` is 1 exactly when `cost16_o` < `cost4_o` + 24*lambda, where lambda is `lambda_i` sampled with the accepted `start_i`. Equality selects 4x4.
- R9: `done_o` is a single-cycle pulse. The result outputs change only in the cycle in which `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a macroblock search (taken only when idle) |
| lambda_i | input | 8 | Lagrange multiplier from the QP-indexed table |
| blk_valid_i | input | 1 | A block pair is presented |
| blk_ready_o | output | 1 | Engine can accept a block pair |
| cur_blk_i | input | 128 | Current 4x4 pixels, pixel i at [8i+7:8i] |
| pred_blk_i | input | 128 | Predicted 4x4 pixels, same packing |
| done_o | output | 1 | One-cycle pulse: results valid |
| use16_o | output | 1 | 1 selects 16x16 luma, 0 selects 4x4 luma |
| l4_modes_o | output | 64 | Best 4x4 mode per block, 4 bits per block |
| l16_mode_o | output | 2 | Best 16x16 luma mode |
| ch_mode_o | output | 2 | Best chroma mode |
| cost4_o | output | 20 | Summed best 4x4 luma cost |
| cost16_o | output | 20 | Best 16x16 luma cost |
| cost_ch_o | output | 20 | Best chroma cost |

## Verification
The hardest conditions to reach are exact equalities: a 16x16 cost equal to the penalised 4x4 cost, and several modes of one block with the same cost. Random pixels almost never produce either. The stimulus builds them on purpose. A single nonzero pixel difference d gives a cost of exactly 8|d|, so a 16x16 cost of 24 against a zero 4x4 cost with lambda 1 hits the boundary, and a cost of 16 falls just below it. Ties among modes come from predictions that repeat for pairs of mode numbers. Saturated plus and minus 255 patterns drive the widest cost paths.

// File: rtl/imd_pkg.sv
package imd_pkg;
  parameter int PIX_W = 8;
  parameter int LAM_W = 8;
  parameter int N4    = 9;
  parameter int N16   = 4;
  parameter int NCH   = 4;
  parameter int B16   = 16;
  parameter int BCH   = 8;

  localparam int DIF_W  = PIX_W + 1;
  localparam int ROW_W  = DIF_W + 2;
  localparam int COL_W  = ROW_W + 2;
  localparam int ACC_W  = COL_W + 3;
  localparam int SATD_W = ACC_W - 1;
  localparam int COST_W = SATD_W + 5;
  localparam int DEC_W  = COST_W + 2;
  localparam int M4_W   = $clog2(N4);
  localparam int M16_W  = $clog2(N16);
  localparam int MCH_W  = $clog2(NCH);
  localparam int BLK_W  = $clog2(B16);

  typedef enum logic [2:0] {PH_IDLE, PH_L4, PH_L16, PH_CH, PH_DEC} phase_e;

  function automatic logic [COL_W-1:0] abs_col(input logic signed [COL_W-1:0] x);
    return x[COL_W-1] ? COL_W'(-x) : COL_W'(x);
  endfunction
endpackage

// File: rtl/imd_satd4x4.sv
module imd_satd4x4
  import imd_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [16*PIX_W-1:0]     cur_i,
  input  logic [16*PIX_W-1:0]     pred_i,
  output logic                    res_valid_o,
  output logic [SATD_W-1:0]       res_o
);
  logic signed [DIF_W-1:0] d_q [4][4];
  logic signed [ROW_W-1:0] h_q [4][4];
  logic [2:0]        cnt_q;
  logic              run_q;
  logic [ACC_W-1:0]  acc_q;
  logic [1:0]        sel;

  assign sel = cnt_q[1:0];

  // stage 1: horizontal transform of one row
  logic signed [ROW_W-1:0] ra [4];
  logic signed [ROW_W-1:0] ro [4];
  // stage 2: vertical transform of one column
  logic signed [COL_W-1:0] ca [4];
  logic signed [COL_W-1:0] co [4];
  logic [ACC_W-1:0] col_sum;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      ra[k] = ROW_W'(d_q[sel][k]);
      ca[k] = COL_W'(h_q[k][sel]);
    end
    ro[0] = ra[0] + ra[1] + ra[2] + ra[3];
    ro[1] = ra[0] + ra[1] - ra[2] - ra[3];
    ro[2] = ra[0] - ra[1] - ra[2] + ra[3];
    ro[3] = ra[0] - ra[1] + ra[2] - ra[3];
    co[0] = ca[0] + ca[1] + ca[2] + ca[3];
    co[1] = ca[0] + ca[1] - ca[2] - ca[3];
    co[2] = ca[0] - ca[1] - ca[2] + ca[3];
    co[3] = ca[0] - ca[1] + ca[2] - ca[3];
    col_sum = '0;
    for (int k = 0; k < 4; k++) col_sum = col_sum + ACC_W'(abs_col(co[k]));
  end

  logic [ACC_W-1:0] acc_nxt;
  assign acc_nxt = acc_q + col_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) begin
          d_q[r][c] <= '0;
          h_q[r][c] <= '0;
        end
      cnt_q       <= '0;
      run_q       <= 1'b0;
      acc_q       <= '0;
      res_valid_o <= 1'b0;
      res_o       <= '0;
    end else begin
      res_valid_o <= 1'b0;
      if (load_i) begin
        for (int r = 0; r < 4; r++)
          for (int c = 0; c < 4; c++)
            d_q[r][c] <= $signed({1'b0, cur_i[(4*r+c)*PIX_W +: PIX_W]})
                       - $signed({1'b0, pred_i[(4*r+c)*PIX_W +: PIX_W]});
        cnt_q <= '0;
        run_q <= 1'b1;
        acc_q <= '0;
      end else if (run_q) begin
        cnt_q <= cnt_q + 3'd1;
        if (!cnt_q[2]) begin
          for (int k = 0; k < 4; k++) h_q[sel][k] <= ro[k];
        end else begin
          acc_q <= acc_nxt;
          if (cnt_q == 3'd7) begin
            run_q       <= 1'b0;
            res_valid_o <= 1'b1;
            res_o       <= SATD_W'(acc_nxt >> 1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/imd_min_track.sv
module imd_min_track
  import imd_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              first_i,
  input  logic [COST_W-1:0] cost_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [COST_W-1:0] best_cost_o,
  output logic [IDX_W-1:0]  best_idx_o
);
  // strict compare keeps the earlier index on ties
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_cost_o <= '0;
      best_idx_o  <= '0;
    end else if (valid_i && (first_i || cost_i < best_cost_o)) begin
      best_cost_o <= cost_i;
      best_idx_o  <= idx_i;
    end
  end
endmodule

// File: rtl/imd_final_cmp.sv
module imd_final_cmp
  import imd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LAM_W-1:0]  lambda_i,
  input  logic [COST_W-1:0] cost4_i,
  input  logic [COST_W-1:0] cost16_i,
  output logic              valid_o,
  output logic              use16_o
);
  logic [2:0]              step_q;
  logic                    act_q;
  logic signed [DEC_W-1:0] pen_q;
  logic signed [DEC_W-1:0] op_a, op_b, sum;
  logic                    sub;

  // one adder shared by all five steps
  always_comb begin
    op_a = pen_q;
    op_b = DEC_W'({lambda_i, 3'b000});
    sub  = 1'b0;
    case (step_q)
      3'd0:    op_a = '0;
      3'd3:    op_b = DEC_W'(cost4_i);
      3'd4: begin
        op_a = DEC_W'(cost16_i);
        op_b = pen_q;
        sub  = 1'b1;
      end
      default: ;
    endcase
    sum = op_a + (sub ? ~op_b : op_b) + DEC_W'(sub);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= '0;
      act_q   <= 1'b0;
      pen_q   <= '0;
      valid_o <= 1'b0;
      use16_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        act_q  <= 1'b1;
        step_q <= '0;
      end else if (act_q) begin
        step_q <= step_q + 3'd1;
        if (step_q == 3'd4) begin
          use16_o <= sum[DEC_W-1];
          valid_o <= 1'b1;
          act_q   <= 1'b0;
        end else begin
          pen_q <= sum;
        end
      end
    end
  end
endmodule

// File: rtl/intra_mode_decide.sv
module intra_mode_decide
  import imd_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [LAM_W-1:0]      lambda_i,
  input  logic                  blk_valid_i,
  output logic                  blk_ready_o,
  input  logic [16*PIX_W-1:0]   cur_blk_i,
  input  logic [16*PIX_W-1:0]   pred_blk_i,
  output logic                  done_o,
  output logic                  use16_o,
  output logic [B16*4-1:0]      l4_modes_o,
  output logic [M16_W-1:0]      l16_mode_o,
  output logic [MCH_W-1:0]      ch_mode_o,
  output logic [COST_W-1:0]     cost4_o,
  output logic [COST_W-1:0]     cost16_o,
  output logic [COST_W-1:0]     cost_ch_o
);
  phase_e             phase_q;
  logic [BLK_W-1:0]   blk_q;
  logic [3:0]         mode_q;
  logic               busy_q;
  logic [LAM_W-1:0]   lam_q;
  logic [COST_W-1:0]  tot4_q, acc16_q, accch_q;
  logic               l4_end_q;
  logic [BLK_W-1:0]   l4_blk_q;
  logic [B16*4-1:0]   l4_modes_q;
  logic               cmp_start_q;

  logic               accept, res_v;
  logic [SATD_W-1:0]  satd;
  logic [COST_W-1:0]  satd_x;
  logic               in_run;

  assign in_run      = (phase_q == PH_L4) || (phase_q == PH_L16) || (phase_q == PH_CH);
  assign blk_ready_o = in_run && !busy_q;
  assign accept      = blk_valid_i && blk_ready_o;
  assign satd_x      = COST_W'(satd);

  imd_satd4x4 u_satd (
    .clk_i, .rst_ni,
    .load_i      (accept),
    .cur_i       (cur_blk_i),
    .pred_i      (pred_blk_i),
    .res_valid_o (res_v),
    .res_o       (satd)
  );

  logic               last4_m, last16_b, lastch_b;
  assign last4_m  = (mode_q == 4'(N4 - 1));
  assign last16_b = (blk_q == BLK_W'(B16 - 1));
  assign lastch_b = (blk_q == BLK_W'(BCH - 1));

  logic [COST_W-1:0]  b4_cost, b16_cost, bch_cost;
  logic [M4_W-1:0]    b4_idx;
  logic [M16_W-1:0]   b16_idx;
  logic [MCH_W-1:0]   bch_idx;

  imd_min_track #(.IDX_W(M4_W)) u_min4 (
    .clk_i, .rst_ni,
    .valid_i     (res_v && phase_q == PH_L4),
    .first_i     (mode_q == 4'd0),
    .cost_i      (satd_x),
    .idx_i       (mode_q[M4_W-1:0]),
    .best_cost_o (b4_cost),
    .best_idx_o  (b4_idx)
  );

  imd_min_track #(.IDX_W(M16_W)) u_min16 (
    .clk_i, .rst_ni,
    .valid_i     (res_v && phase_q == PH_L16 && last16_b),
    .first_i     (mode_q == 4'd0),
    .cost_i      (acc16_q + satd_x),
    .idx_i       (mode_q[M16_W-1:0]),
    .best_cost_o (b16_cost),
    .best_idx_o  (b16_idx)
  );

  imd_min_track #(.IDX_W(MCH_W)) u_minch (
    .clk_i, .rst_ni,
    .valid_i     (res_v && phase_q == PH_CH && lastch_b),
    .first_i     (mode_q == 4'd0),
    .cost_i      (accch_q + satd_x),
    .idx_i       (mode_q[MCH_W-1:0]),
    .best_cost_o (bch_cost),
    .best_idx_o  (bch_idx)
  );

  logic cmp_valid, cmp_use16;

  imd_final_cmp u_cmp (
    .clk_i, .rst_ni,
    .start_i  (cmp_start_q),
    .lambda_i (lam_q),
    .cost4_i  (tot4_q),
    .cost16_i (b16_cost),
    .valid_o  (cmp_valid),
    .use16_o  (cmp_use16)
  );

  // search sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      blk_q       <= '0;
      mode_q      <= '0;
      busy_q      <= 1'b0;
      lam_q       <= '0;
      acc16_q     <= '0;
      accch_q     <= '0;
      cmp_start_q <= 1'b0;
    end else begin
      cmp_start_q <= 1'b0;
      if (accept) busy_q <= 1'b1;
      if (res_v)  busy_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_L4;
          blk_q   <= '0;
          mode_q  <= '0;
          lam_q   <= lambda_i;
        end
        PH_L4: if (res_v) begin
          if (last4_m) begin
            mode_q <= '0;
            blk_q  <= blk_q + 1'b1;
            if (last16_b) phase_q <= PH_L16;
          end else begin
            mode_q <= mode_q + 4'd1;
          end
        end
        PH_L16: if (res_v) begin
          acc16_q <= (blk_q == '0) ? satd_x : acc16_q + satd_x;
          if (last16_b) begin
            blk_q  <= '0;
            mode_q <= mode_q + 4'd1;
            if (mode_q == 4'(N16 - 1)) begin
              mode_q  <= '0;
              phase_q <= PH_CH;
            end
          end else begin
            blk_q <= blk_q + 1'b1;
          end
        end
        PH_CH: if (res_v) begin
          accch_q <= (blk_q == '0) ? satd_x : accch_q + satd_x;
          if (lastch_b) begin
            blk_q  <= '0;
            mode_q <= mode_q + 4'd1;
            if (mode_q == 4'(NCH - 1)) begin
              mode_q      <= '0;
              phase_q     <= PH_DEC;
              cmp_start_q <= 1'b1;
            end
          end else begin
            blk_q <= blk_q + 1'b1;
          end
        end
        PH_DEC: if (cmp_valid) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // 4x4 per-block winner accumulation, one cycle after the tracker settles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l4_end_q   <= 1'b0;
      l4_blk_q   <= '0;
      tot4_q     <= '0;
      l4_modes_q <= '0;
    end else begin
      l4_end_q <= res_v && phase_q == PH_L4 && last4_m;
      if (res_v) l4_blk_q <= blk_q;
      if (phase_q == PH_IDLE && start_i) begin
        tot4_q <= '0;
      end else if (l4_end_q) begin
        tot4_q <= tot4_q + b4_cost;
        l4_modes_q[4*l4_blk_q +: 4] <= 4'(b4_idx);
      end
    end
  end

  // result registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      use16_o    <= 1'b0;
      l4_modes_o <= '0;
      l16_mode_o <= '0;
      ch_mode_o  <= '0;
      cost4_o    <= '0;
      cost16_o   <= '0;
      cost_ch_o  <= '0;
    end else begin
      done_o <= cmp_valid;
      if (cmp_valid) begin
        use16_o    <= cmp_use16;
        l4_modes_o <= l4_modes_q;
        l16_mode_o <= b16_idx;
        ch_mode_o  <= bch_idx;
        cost4_o    <= tot4_q;
        cost16_o   <= b16_cost;
        cost_ch_o  <= bch_cost;
      end
    end
  end
endmodule

// File: rtl/imd_chk.sv
module imd_chk
  import imd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              blk_valid_i,
  input logic              blk_ready_o,
  input logic              done_o,
  input logic              use16_o,
  input logic [B16*4-1:0]  l4_modes_o,
  input logic [COST_W-1:0] cost4_o,
  input logic [COST_W-1:0] cost16_o
);
  assert_one_in_flight_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_i && blk_ready_o) |=> !blk_ready_o);

  assert_idle_at_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !blk_ready_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_use16_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(use16_o) |-> done_o);

  assert_cost_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cost4_o) || !$stable(cost16_o)) |-> done_o);

  for (genvar g = 0; g < B16; g++) begin : g_mode
    assert_mode_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      l4_modes_o[4*g +: 4] < 4'(N4));
  end
endmodule

bind intra_mode_decide imd_chk u_imd_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .blk_valid_i (blk_valid_i),
  .blk_ready_o (blk_ready_o),
  .done_o      (done_o),
  .use16_o     (use16_o),
  .l4_modes_o  (l4_modes_o),
  .cost4_o     (cost4_o),
  .cost16_o    (cost16_o)
);

// File: tb/intra_mode_decide_bench.sv
module intra_mode_decide_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [7:0]   lam = '0;
  logic         bvalid = 1'b0;
  logic         bready;
  logic [127:0] cur = '0, pred = '0;
  logic         done, use16;
  logic [63:0]  l4m;
  logic [1:0]   l16m, chm;
  logic [19:0]  c4, c16, cch;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intra_mode_decide u_intra_mode_decide (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lambda_i(lam),
    .blk_valid_i(bvalid), .blk_ready_o(bready), .cur_blk_i(cur), .pred_blk_i(pred),
    .done_o(done), .use16_o(use16), .l4_modes_o(l4m), .l16_mode_o(l16m),
    .ch_mode_o(chm), .cost4_o(c4), .cost16_o(c16), .cost_ch_o(cch)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d exp<%0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int unsigned hsh(int ph, int blk, int mode, int i, int p);
    int unsigned x;
    x = ph*7919 + blk*104729 + mode*1299709 + i*15485863 + p*32452843 + 17;
    x = x ^ (x >> 13);
    x = x * 32'h5bd1e995;
    x = x ^ (x >> 15);
    return x;
  endfunction

  // kinds: 0 flat, 1 random, 2 saturated, 3 paired ties, 4/5 single-pixel 16x16 step 3/2
  function automatic int px(int kind, int ph, int blk, int mode, int i, int p);
    int b;
    case (kind)
      1: return int'(hsh(ph, blk, mode, i, p) & 255);
      2: begin
        b = ((i ^ (i >> 2)) + mode + blk) & 1;
        return (b ^ p) ? 255 : 0;
      end
      3: return p ? 128 : int'(hsh(ph, blk, mode >> 1, i, 0) & 255);
      4: return (ph == 1 && blk == 0 && i == 5 && p == 0) ? 103 : 100;
      5: return (ph == 1 && blk == 0 && i == 5 && p == 0) ? 102 : 100;
      default: return 100;
    endcase
  endfunction

  function automatic int hs(int r, int k);
    case (r)
      0: return 1;
      1: return (k < 2) ? 1 : -1;
      2: return (k == 0 || k == 3) ? 1 : -1;
      default: return (k == 0 || k == 2) ? 1 : -1;
    endcase
  endfunction

  // R3 reference: half the absolute sum of the 2-D Hadamard transform
  function automatic int satd_ref(int kind, int ph, int blk, int mode);
    int d [4][4];
    int s, t;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        d[r][c] = px(kind, ph, blk, mode, 4*r+c, 0) - px(kind, ph, blk, mode, 4*r+c, 1);
    s = 0;
    for (int u = 0; u < 4; u++)
      for (int v = 0; v < 4; v++) begin
        t = 0;
        for (int r = 0; r < 4; r++)
          for (int c = 0; c < 4; c++) t += hs(u, r) * d[r][c] * hs(v, c);
        s += (t < 0) ? -t : t;
      end
    return s / 2;
  endfunction

  task automatic send(input int kind, input int ph, input int blk, input int mode, input bit probe);
    for (int i = 0; i < 16; i++) begin
      cur[8*i +: 8]  = 8'(px(kind, ph, blk, mode, i, 0));
      pred[8*i +: 8] = 8'(px(kind, ph, blk, mode, i, 1));
    end
    while (!bready) @(negedge clk);
    bvalid = 1'b1;
    @(negedge clk);
    bvalid = 1'b0;
    if (probe) chk(!bready, "R2 ready low while pair in flight", bready, 0);
  endtask

  task automatic run_mb(input int kind, input int lv, input bit glitch);
    int e4, b, bm, c, e16, m16, ech, mch, n, w;
    int em [16];
    bit eu;
    e4 = 0;
    for (int k = 0; k < 16; k++) begin
      b = satd_ref(kind, 0, k, 0); bm = 0;
      for (int m = 1; m < 9; m++) begin
        c = satd_ref(kind, 0, k, m);
        if (c < b) begin b = c; bm = m; end
      end
      e4 += b; em[k] = bm;
    end
    for (int m = 0; m < 4; m++) begin
      c = 0;
      for (int k = 0; k < 16; k++) c += satd_ref(kind, 1, k, m);
      if (m == 0 || c < e16) begin e16 = c; m16 = m; end
    end
    for (int m = 0; m < 4; m++) begin
      c = 0;
      for (int k = 0; k < 8; k++) c += satd_ref(kind, 2, k, m);
      if (m == 0 || c < ech) begin ech = c; mch = m; end
    end
    eu = (e16 < e4 + 24*lv);

    lam = 8'(lv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lam = 8'(lv ^ 8'h5a);  // must not matter after start (R8)
    n = 0;
    for (int k = 0; k < 16; k++)
      for (int m = 0; m < 9; m++) begin
        send(kind, 0, k, m, n == 0);
        n++;
        if (glitch && n == 50) begin
          start = 1'b1; @(negedge clk); start = 1'b0;
        end
      end
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 16; k++) send(kind, 1, k, m, 1'b0);
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 8; k++) send(kind, 2, k, m, 1'b0);
    chk(!bready, "R2 ready low after last pair", bready, 0);
    w = 0;
    while (!done && w < 200) begin @(negedge clk); w++; end
    chk(done, "R9 done pulse arrives", done, 1);
    for (int k = 0; k < 16; k++)
      chk(l4m[4*k +: 4] == 4'(em[k]), "R4 best 4x4 mode", l4m[4*k +: 4], em[k]);
    chk(c4 == 20'(e4), "R5 4x4 cost sum (R3 costs)", c4, e4);
    chk(c16 == 20'(e16), "R6 16x16 cost", c16, e16);
    chk(l16m == 2'(m16), "R6 16x16 mode", l16m, m16);
    chk(cch == 20'(ech), "R7 chroma cost", cch, ech);
    chk(chm == 2'(mch), "R7 chroma mode", chm, mch);
    chk(use16 == eu, "R8 4x4 vs 16x16 decision", use16, eu);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    chk(c4 == 20'(e4) && use16 == eu, "R9 results held", c4, e4);
    chk(!bready, "R2 idle after done", bready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !bready, "R1 reset outputs", {done, bready}, 0);
    chk(c4 == 0 && c16 == 0 && l4m == 0 && !use16, "R1 reset results", c4, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !bready, "R1 idle after reset", {done, bready}, 0);
    run_mb(0, 0, 1'b0);    // all zero, equality -> 4x4
    run_mb(0, 1, 1'b0);    // all zero, penalty -> 16x16
    run_mb(1, 10, 1'b0);
    run_mb(2, 200, 1'b0);  // saturated differences
    run_mb(3, 5, 1'b0);    // mode ties
    run_mb(4, 1, 1'b0);    // 24 vs 0+24: equal -> 4x4
    run_mb(5, 1, 1'b0);    // 16 vs 24 -> 16x16
    run_mb(1, 0, 1'b1);    // start pulse mid-run ignored (R2)
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule